// File: doc/BRIEF.md
# Hierarchical State-Enable Control Registers

This block holds the state-enable control registers of a core with machine, hypervisor and supervisor privilege levels. Each level has a main enable register, which carries a few standard enable bits and two special bits. Each level also has a separate custom enable register with one enable bit per subset of implementation-defined extra state. The two special bits in a main register act on that level's custom enable vector. The bulk-set bit turns every implemented custom enable on. The bulk-clear bit turns them all off. When read, the bulk-clear bit reports whether any custom enable is on. Because of this, software can grant or revoke all extra state without knowing how that state is laid out, and a read-modify-write of a main register leaves the custom vector as it was.

The block also answers access checks. A requester names a gated resource, which is either a standard enable index or a custom enable index. The block combines the enables of every more-privileged level that gates the requester's current mode. If any of them is off, it raises a trap. A block at machine level gives an illegal-instruction trap. A block at a lower level gives a virtual-instruction trap when virtualization is active, and an illegal-instruction trap when it is not. CSR accesses are also checked against the privilege that owns each register.

Top module: `sten_ctrl`

## Requirements
- R1: After reset, every standard and custom enable bit is 0. All registers read 0, and a user-mode check of any resource raises an illegal-instruction trap.
- R2: Writing a main register with bit XLEN-2 (bulk-set) at 1 and bit XLEN-1 at 1 sets every implemented bit of that level's custom vector. Bulk-set always reads 0, and writing 0 to it has no effect.
- R3: Bit XLEN-1 of a main register reads 1 exactly when at least one bit of that level's custom vector is 1.
- R4: Writing a main register with bit XLEN-1 at 0 clears that level's custom vector. This clear takes precedence over a bulk-set in the same write.
- R5: Writing a main register with bulk-set at 0 and bit XLEN-1 at 1 leaves the custom vector unchanged. Writing back a value that was read from the register therefore preserves the custom enables.
- R6: The custom enable registers are at addresses 4 (machine), 5 (hypervisor) and 6 (supervisor), and the main registers are at addresses 0, 1 and 2. A custom register is read and written directly through its low CUST_W bits, masked by CUST_MASK.
- R7: Privilege is encoded 3 = machine, 1 = supervisor, 0 = user. Machine registers need privilege 3. Hypervisor registers need privilege 3, or privilege 1 with virt at 0. Supervisor registers need privilege 3 or 1. Any other access raises csr_ill, reads 0 and changes nothing.
- R8: A resource index below STD_W selects standard bit [index]. An index from STD_W up to STD_W+CUST_W-1 selects custom bit [index-STD_W]. A supervisor-mode check is gated by the machine level; with virt at 1 the hypervisor level also gates it. A user-mode check is gated by the machine and supervisor levels, plus the hypervisor level when virt is 1. The check is allowed only if every gating bit is 1.
- R9: A check blocked at machine level raises chk_ill. A check allowed at machine level but blocked lower raises chk_virt if virt is 1, and chk_ill otherwise. The two are never raised together.
- R10: Main-register bits STD_W through XLEN-3, custom bits outside CUST_MASK, and unmapped addresses all read 0, even after ones are written to them.
- R11: A check made at machine privilege never traps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| csr_en | input | 1 | CSR access valid this cycle |
| csr_we | input | 1 | Access is a write |
| csr_addr | input | 3 | Register select |
| csr_wdata | input | XLEN | Write data |
| priv | input | 2 | Current privilege |
| virt | input | 1 | Virtualization active |
| csr_rdata | output | XLEN | Read data, combinational |
| csr_ill | output | 1 | CSR access denied by privilege |
| chk_en | input | 1 | Access check valid |
| chk_res | input | RES_W | Gated resource index |
| chk_ill | output | 1 | Illegal-instruction trap for the check |
| chk_virt | output | 1 | Virtual-instruction trap for the check |

## Verification
The bench builds the block with its defaults: XLEN 32, four standard bits, and four custom bits with mask 1011. Bulk-set and bulk-clear therefore sit at bits 30 and 31. Custom bit 2 is unimplemented, so both bulk-set and direct writes can be shown to leave it at 0. The four standard bits and the masked custom vector give enough independent enables per level that, for each privilege and virtualization mode, checks can be blocked at one specific level while the others stay open. This separates the illegal-instruction and virtual-instruction outcomes.

// File: rtl/sten_pkg.sv
package sten_pkg;

  typedef enum logic [1:0] {
    PRV_U = 2'b00,
    PRV_S = 2'b01,
    PRV_M = 2'b11
  } priv_e;

  typedef enum logic [1:0] {
    LVL_M = 2'd0,
    LVL_H = 2'd1,
    LVL_S = 2'd2,
    LVL_NONE = 2'd3
  } lvl_e;

  // Owner rule for a level's registers.
  function automatic logic may_access(input logic [1:0] lvl, input logic [1:0] prv,
                                      input logic vrt);
    logic ok;
    case (lvl)
      LVL_M:   ok = (prv == PRV_M);
      LVL_H:   ok = (prv == PRV_M) || (prv == PRV_S && !vrt);
      LVL_S:   ok = (prv == PRV_M) || (prv == PRV_S);
      default: ok = 1'b0;
    endcase
    return ok;
  endfunction

endpackage

// File: rtl/sten_level_bank.sv
module sten_level_bank #(
  parameter int XLEN = 32,
  parameter int STD_W = 4,
  parameter int CUST_W = 4,
  parameter logic [CUST_W-1:0] CUST_MASK = 'b1011
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_main,
  input  logic              wr_cust,
  input  logic [STD_W-1:0]  std_wd,
  input  logic              set_wd,
  input  logic              any_wd,
  input  logic [CUST_W-1:0] cust_wd,
  output logic [STD_W-1:0]  std_q,
  output logic [CUST_W-1:0] cust_q,
  output logic [XLEN-1:0]   main_rd
);
  localparam int ANY_BIT = XLEN - 1;

  logic any_on;
  logic [CUST_W-1:0] cust_side;

  // Side effect of a main-register write on the custom vector.
  function automatic logic [CUST_W-1:0] side_effect(input logic [CUST_W-1:0] cur,
                                                    input logic s, input logic a);
    if (!a)     return '0;
    else if (s) return CUST_MASK;
    else        return cur;
  endfunction

  assign any_on    = |cust_q;
  assign cust_side = side_effect(cust_q, set_wd, any_wd);

  always_comb begin
    main_rd = '0;
    main_rd[STD_W-1:0] = std_q;
    main_rd[ANY_BIT] = any_on;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      std_q  <= '0;
      cust_q <= '0;
    end else begin
      if (wr_main) std_q <= std_wd;
      if (wr_cust)      cust_q <= cust_wd & CUST_MASK;
      else if (wr_main) cust_q <= cust_side;
    end
  end

  // R2
  bulk_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_main && set_wd && any_wd |=> cust_q == CUST_MASK);
  // R4
  bulk_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_main && !any_wd |=> cust_q == '0);
  // R5
  rmw_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_main && !wr_cust && !set_wd && any_wd |=> $stable(cust_q));
endmodule

// File: rtl/sten_access_check.sv
module sten_access_check
  import sten_pkg::*;
#(
  parameter int STD_W = 4,
  parameter int CUST_W = 4,
  parameter int RES_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic [RES_W-1:0]  res,
  input  logic [1:0]        prv,
  input  logic              vrt,
  input  logic [STD_W-1:0]  std_m,
  input  logic [STD_W-1:0]  std_h,
  input  logic [STD_W-1:0]  std_s,
  input  logic [CUST_W-1:0] cust_m,
  input  logic [CUST_W-1:0] cust_h,
  input  logic [CUST_W-1:0] cust_s,
  output logic              ill,
  output logic              vtrap
);
  // Select the enable bit a resource index refers to at one level.
  function automatic logic pick(input logic [STD_W-1:0] s, input logic [CUST_W-1:0] c,
                                input logic [RES_W-1:0] r);
    logic b;
    b = 1'b0;
    for (int i = 0; i < STD_W; i++)
      if (int'(r) == i) b = s[i];
    for (int j = 0; j < CUST_W; j++)
      if (int'(r) == STD_W + j) b = c[j];
    return b;
  endfunction

  logic en_m, en_h, en_s;
  logic need_m, need_h, need_s;
  logic m_block, low_block;

  assign en_m = pick(std_m, cust_m, res);
  assign en_h = pick(std_h, cust_h, res);
  assign en_s = pick(std_s, cust_s, res);

  assign need_m = (prv != PRV_M);
  assign need_h = need_m && vrt;
  assign need_s = need_m && (prv != PRV_S);

  assign m_block   = need_m && !en_m;
  assign low_block = (need_h && !en_h) || (need_s && !en_s);

  assign ill   = en && (m_block || (low_block && !vrt));
  assign vtrap = en && !m_block && low_block && vrt;

  // R9
  one_trap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(ill && vtrap));
  // R9
  virt_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    vtrap |-> vrt);
  // R11
  m_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
    en && prv == PRV_M |-> !ill && !vtrap);
endmodule

// File: rtl/sten_ctrl.sv
module sten_ctrl
  import sten_pkg::*;
#(
  parameter int XLEN = 32,
  parameter int STD_W = 4,
  parameter int CUST_W = 4,
  parameter logic [CUST_W-1:0] CUST_MASK = 'b1011,
  parameter int RES_W = $clog2(STD_W + CUST_W)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             csr_en,
  input  logic             csr_we,
  input  logic [2:0]       csr_addr,
  input  logic [XLEN-1:0]  csr_wdata,
  input  logic [1:0]       priv,
  input  logic             virt,
  output logic [XLEN-1:0]  csr_rdata,
  output logic             csr_ill,
  input  logic             chk_en,
  input  logic [RES_W-1:0] chk_res,
  output logic             chk_ill,
  output logic             chk_virt
);
  localparam int SET_BIT = XLEN - 2;
  localparam int ANY_BIT = XLEN - 1;
  localparam int NLVL = 3;

  logic [1:0] sel_lvl;
  logic       sel_cust, mapped, allowed, do_wr;
  logic       wdata_unused;

  logic [STD_W-1:0]  std_q  [NLVL];
  logic [CUST_W-1:0] cust_q [NLVL];
  logic [XLEN-1:0]   main_rd[NLVL];

  assign sel_lvl  = csr_addr[1:0];
  assign sel_cust = csr_addr[2];
  assign mapped   = (sel_lvl != LVL_NONE);
  assign allowed  = mapped && may_access(sel_lvl, priv, virt);
  assign csr_ill  = csr_en && mapped && !allowed;
  assign do_wr    = csr_en && csr_we && allowed;
  assign wdata_unused = ^csr_wdata;

  for (genvar l = 0; l < NLVL; l++) begin : g_lvl
    sten_level_bank #(
      .XLEN(XLEN), .STD_W(STD_W), .CUST_W(CUST_W), .CUST_MASK(CUST_MASK)
    ) u_bank (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_main (do_wr && !sel_cust && sel_lvl == 2'(l)),
      .wr_cust (do_wr && sel_cust && sel_lvl == 2'(l)),
      .std_wd  (csr_wdata[STD_W-1:0]),
      .set_wd  (csr_wdata[SET_BIT]),
      .any_wd  (csr_wdata[ANY_BIT]),
      .cust_wd (csr_wdata[CUST_W-1:0]),
      .std_q   (std_q[l]),
      .cust_q  (cust_q[l]),
      .main_rd (main_rd[l])
    );
  end

  always_comb begin
    csr_rdata = '0;
    if (csr_en && allowed) begin
      for (int l = 0; l < NLVL; l++) begin
        if (sel_lvl == 2'(l)) begin
          if (sel_cust) csr_rdata[CUST_W-1:0] = cust_q[l];
          else          csr_rdata = main_rd[l];
        end
      end
    end
  end

  sten_access_check #(.STD_W(STD_W), .CUST_W(CUST_W), .RES_W(RES_W)) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .en     (chk_en),
    .res    (chk_res),
    .prv    (priv),
    .vrt    (virt),
    .std_m  (std_q[0]),
    .std_h  (std_q[1]),
    .std_s  (std_q[2]),
    .cust_m (cust_q[0]),
    .cust_h (cust_q[1]),
    .cust_s (cust_q[2]),
    .ill    (chk_ill),
    .vtrap  (chk_virt)
  );

  logic [NLVL*(STD_W+CUST_W)-1:0] all_q;
  assign all_q = {std_q[0], std_q[1], std_q[2], cust_q[0], cust_q[1], cust_q[2]};

  // R7
  denied_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    csr_ill |=> $stable(all_q));
  // R7
  denied_rd_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    csr_ill |-> csr_rdata == '0);
endmodule

// File: tb/sim_sten_ctrl.sv
`timescale 1ns/1ps
module sim_sten_ctrl;
  localparam int XLEN = 32;
  localparam int RES_W = 3;
  localparam logic [31:0] SB = 32'h4000_0000;  // bulk-set bit 30
  localparam logic [31:0] AB = 32'h8000_0000;  // any/clear bit 31
  localparam logic [1:0] KW = 0, KR = 1, KC = 2;
  localparam logic [1:0] PM = 3, PS = 1, PU = 0;

  logic clk = 0, rst_n = 0;
  logic csr_en = 0, csr_we = 0, virt = 0, chk_en = 0;
  logic [2:0] csr_addr = 0;
  logic [XLEN-1:0] csr_wdata = 0;
  logic [1:0] priv = 0;
  logic [RES_W-1:0] chk_res = 0;
  logic [XLEN-1:0] csr_rdata;
  logic csr_ill, chk_ill, chk_virt;
  int total = 0, bad = 0;
  bit done = 0;

  always #2 clk = ~clk;

  sten_ctrl u0 (.*);

  function automatic logic [75:0] mk(input logic [1:0] k, input logic [2:0] a,
                                     input logic [1:0] p, input logic v,
                                     input logic [31:0] d, input logic [31:0] e,
                                     input logic [3:0] r);
    return {k, a, p, v, d, e, r};
  endfunction

  localparam int N = 36;
  localparam logic [75:0] TBL [N] = '{
    mk(KR, 0, PM, 0, 0, 0, 1),          // R1 reset read
    mk(KC, 0, PU, 0, 0, 2, 1),          // R1 user blocked
    mk(KW, 0, PM, 0, AB|SB|5, 0, 2),    // R2 bulk-set machine
    mk(KR, 0, PM, 0, 0, AB|5, 3),       // R3 any reads 1, set reads 0
    mk(KR, 4, PM, 0, 0, 32'hB, 2),      // R2 all implemented set
    mk(KC, 0, PS, 0, 0, 0, 8),          // R8
    mk(KC, 1, PS, 0, 0, 2, 8),          // R8
    mk(KC, 6, PS, 0, 0, 2, 10),         // R10 custom bit 2 unimplemented
    mk(KC, 4, PS, 0, 0, 0, 8),          // R8
    mk(KW, 1, PS, 1, AB|SB|15, 1, 7),   // R7 virtual S cannot own H
    mk(KR, 1, PM, 0, 0, 0, 7),          // R7 unchanged
    mk(KW, 1, PS, 0, AB|1, 0, 5),       // R5
    mk(KR, 5, PM, 0, 0, 0, 5),          // R5
    mk(KC, 0, PS, 1, 0, 0, 8),          // R8
    mk(KC, 4, PS, 1, 0, 1, 9),          // R9 virtual trap from H
    mk(KC, 1, PS, 1, 0, 2, 9),          // R9 machine block wins
    mk(KW, 2, PS, 0, AB|SB, 0, 2),      // R2 bulk-set supervisor
    mk(KC, 0, PU, 0, 0, 2, 9),          // R9 nonvirtual lower block
    mk(KC, 0, PU, 1, 0, 1, 9),          // R9 virtual lower block
    mk(KC, 4, PU, 0, 0, 0, 8),          // R8
    mk(KW, 6, PS, 0, 6, 0, 6),          // R6 direct write masked
    mk(KR, 6, PS, 0, 0, 2, 6),          // R6
    mk(KR, 2, PS, 0, 0, AB, 3),         // R3
    mk(KW, 2, PS, 0, AB, 0, 5),         // R5 write back read value
    mk(KR, 6, PS, 0, 0, 2, 5),          // R5
    mk(KW, 2, PS, 0, SB, 0, 4),         // R4 clear beats set
    mk(KR, 6, PS, 0, 0, 0, 4),          // R4
    mk(KR, 2, PS, 0, 0, 0, 3),          // R3 none on
    mk(KW, 0, PM, 0, 32'h3FFF_FFFF, 0, 10), // R10
    mk(KR, 0, PM, 0, 0, 32'hF, 10),     // R10
    mk(KR, 4, PM, 0, 0, 0, 4),          // R4
    mk(KC, 4, PM, 0, 0, 0, 11),         // R11
    mk(KW, 4, PS, 0, 15, 1, 7),         // R7
    mk(KW, 2, PU, 0, AB|SB, 1, 7),      // R7
    mk(KW, 5, PM, 0, 32'hFFFF_FFFF, 0, 6), // R6
    mk(KR, 5, PM, 0, 0, 32'hB, 6)       // R6
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic run(input logic [75:0] e);
    logic [1:0] k; logic [31:0] d, x; logic [3:0] r; string tag;
    {k, csr_addr, priv, virt, d, x, r} = e;
    tag = $sformatf("R%0d", r);
    @(negedge clk);
    if (k == KC) begin
      chk_en = 1; chk_res = csr_addr;
      #1 check(tag, {30'd0, chk_ill, chk_virt}, x);
      chk_en = 0;
    end else begin
      csr_en = 1; csr_we = (k == KW); csr_wdata = d;
      #1;
      if (k == KW) check(tag, {31'd0, csr_ill}, x);
      else check(tag, csr_rdata, x);
      @(posedge clk); #1;
      csr_en = 0; csr_we = 0;
    end
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    #9 rst_n = 1;
    for (int i = 0; i < N; i++) run(TBL[i]);
    // R1: reset in the middle of activity returns everything to 0
    @(negedge clk); rst_n = 0; #1 rst_n = 1;
    run(mk(KR, 5, PM, 0, 0, 0, 1));  // R1
    run(mk(KR, 0, PM, 0, 0, 0, 1));  // R1
    run(mk(KC, 4, PS, 0, 0, 2, 1));  // R1
    run(mk(KR, 3, PM, 0, 0, 0, 10)); // R10 unmapped reads 0
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule